// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path with Two-Stage Deselect

This block is the read-data and output-enable path of a synchronous burst SRAM. Each clock edge samples a command formed from a chip-enable and a read qualifier. A read command makes the block drive a word taken from the array onto the data bus. Any other command (chip-enable low, or chip-enable high with the read qualifier low) counts as a deselect, and the bus is released. The array, the address generation and the write path sit outside this block.

A run-time mode input selects the read latency. In flow-through mode the array word goes straight to the bus. In pipeline mode the word passes through a rising-edge output register, which adds one cycle. A deselect travels through the same number of stages as a read, so in pipeline mode the bus is released only after the second edge following the deselect. A read that directly follows a deselect still appears at its normal latency. An output-enable input gates the bus with no clock involved.

Top module: `sram_rd_path`

## Requirements
- R1: While reset is asserted, dq_oe_o is 0 and dq_o is all zeros, whatever the command, mode and output-enable inputs are. The same holds for two edges after reset is released, because reset leaves the block through a two-flop synchronizer.
- R2: With pipe_mode_i = 0 (flow-through), a read (ce_i = 1 and rd_i = 1) sampled at edge n drives arr_data_i onto dq_o in the cycle between edge n and edge n+1. The bus follows arr_data_i within that cycle.
- R3: With pipe_mode_i = 1 (pipeline), a read sampled at edge n is driven in the cycle between edge n+1 and edge n+2. The word driven is the value arr_data_i had between edge n and edge n+1, captured at edge n+1.
- R4: A deselect (ce_i = 0, or ce_i = 1 with rd_i = 0) sampled at edge n releases the bus after edge n in flow-through mode and after edge n+1 in pipeline mode. In pipeline mode the word of a read sampled at edge n-1 is still driven between edge n and edge n+1.
- R5: Back-to-back reads produce one new word per cycle in both modes once the first word has appeared.
- R6: A read sampled directly after a deselect is driven at its normal latency for the current mode.
- R7: oe_i = 0 forces dq_oe_o to 0 within the same cycle, with no clock edge. Returning oe_i to 1 restores the drive state that the command pipeline selects.
- R8: Whenever dq_oe_o is 0, dq_o is all zeros. This lets the pad cell treat the bus as high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously and releases synchronously |
| pipe_mode_i | input | 1 | 1 = pipeline (registered output), 0 = flow-through |
| ce_i | input | 1 | Chip enable for the command sampled this edge |
| rd_i | input | 1 | Read qualifier; a read needs ce_i = 1 and rd_i = 1 |
| oe_i | input | 1 | Output enable, acts without a clock edge |
| arr_data_i | input | DATA_W | Word read from the array in the cycle after the command |
| dq_o | output | DATA_W | Data bus value; all zeros when not driven |
| dq_oe_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The hardest case to reach is the pipeline cycle in which a deselect has already been sampled but the previous read's word must still be on the bus. A check there fails only if a design releases the bus one edge too early. The stimulus reaches this cycle by following a pipelined burst directly with a deselect, and then a read right after that. Both deselect forms are used: chip-enable low, and a non-read command. The bench also drops and restores the output enable in the middle of a cycle, away from any edge, so that gating the enable through a register would be caught.

// File: rtl/sram_rd_path_pkg.sv
package sram_rd_path_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rdp_rst_sync.sv
module rdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rdp_en_pipe.sv
module rdp_en_pipe
  import sram_rd_path_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rd_mode_e mode_i,
  input  logic     cmd_rd_i,
  output logic     stage1_o,
  output logic     en_o
);
  logic s1_q, s1_d, s2_q, s2_d;

  always_comb begin
    s1_d = cmd_rd_i;
    s2_d = s1_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign stage1_o = s1_q;
  assign en_o     = (mode_i == MODE_PIPE) ? s2_q : s1_q;

  AST_FT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FLOW && $past(cmd_rd_i) && $past(rst_ni)) |-> en_o); // R2
  AST_PIPE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PIPE && $past(cmd_rd_i, 2) && $past(rst_ni) && $past(rst_ni, 2)) |-> en_o); // R3
  AST_FT_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FLOW && !$past(cmd_rd_i)) |-> !en_o); // R4
  AST_PIPE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PIPE && !$past(cmd_rd_i, 2)) |-> !en_o); // R4
endmodule

// File: rtl/rdp_data_stage.sv
module rdp_data_stage
  import sram_rd_path_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_mode_e          mode_i,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] arr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (cap_en_i) word_d = arr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign data_o = (mode_i == MODE_PIPE) ? word_q : arr_i;
endmodule

// File: rtl/rdp_out_drive.sv
module rdp_out_drive #(
  parameter int DATA_W = 36
) (
  input  logic              en_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  assign dq_oe_o = en_i & oe_i;
  assign dq_o    = dq_oe_o ? data_i : '0;

  always_comb begin
    AST_OE_GATE: assert (oe_i || !dq_oe_o); // R7
    AST_IDLE_ZERO: assert (dq_oe_o || (dq_o == '0)); // R8
  end
endmodule

// File: rtl/sram_rd_path.sv
module sram_rd_path
  import sram_rd_path_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int RST_STAGE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_mode_i,
  input  logic              ce_i,
  input  logic              rd_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              rst_sync_n;
  logic              stage1;
  logic              drive_en;
  logic [DATA_W-1:0] rd_word;
  rd_mode_e          mode;

  assign mode = rd_mode_e'(pipe_mode_i);

  rdp_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  rdp_en_pipe u_en_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .mode_i   (mode),
    .cmd_rd_i (ce_i & rd_i),
    .stage1_o (stage1),
    .en_o     (drive_en)
  );

  rdp_data_stage #(.DATA_W(DATA_W)) u_data_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .mode_i   (mode),
    .cap_en_i (stage1),
    .arr_i    (arr_data_i),
    .data_o   (rd_word)
  );

  rdp_out_drive #(.DATA_W(DATA_W)) u_out_drive (
    .en_i    (drive_en),
    .oe_i    (oe_i),
    .data_i  (rd_word),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk_i) !rst_sync_n |-> !dq_oe_o); // R1
endmodule

// File: tb/sram_rd_path_bench.sv
module sram_rd_path_bench;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pipe_mode = 1'b0;
  logic         ce = 1'b0;
  logic         rd = 1'b0;
  logic         oe = 1'b0;
  logic [W-1:0] arr = '0;
  logic [W-1:0] dq;
  logic         dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic         oe;
    logic [W-1:0] dq;
    string        tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  logic         c1 = 1'b0;
  logic         c2 = 1'b0;
  logic [W-1:0] a1 = '0;

  always #5 clk = ~clk;

  sram_rd_path #(.DATA_W(W)) u_sram_rd_path (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pipe_mode_i (pipe_mode),
    .ce_i        (ce),
    .rd_i        (rd),
    .oe_i        (oe),
    .arr_data_i  (arr),
    .dq_o        (dq),
    .dq_oe_o     (dq_oe)
  );

  task automatic chk(input string tag, input logic act_oe, input logic [W-1:0] act_dq,
                     input logic exp_oe, input logic [W-1:0] exp_dq);
    checks++;
    if (act_oe !== exp_oe || act_dq !== exp_dq) begin
      errors++;
      $display("FAIL %s: actual oe=%0b dq=%h expected oe=%0b dq=%h",
               tag, act_oe, act_dq, exp_oe, exp_dq);
    end
  endtask

  // Driver: sets inputs for one cycle and queues the expected bus state.
  task automatic step(input logic m, input logic c, input logic r, input logic o,
                      input logic [W-1:0] a, input string tag);
    exp_t e;
    logic en;
    logic [W-1:0] d;
    @(posedge clk); #1;
    pipe_mode = m; ce = c; rd = r; oe = o; arr = a;
    en = m ? c2 : c1;
    d  = m ? a1 : a;
    e.oe  = en & o;
    e.dq  = e.oe ? d : '0;
    e.tag = tag;
    exp_q.push_back(e);
    c2 = c1;
    c1 = c & r;
    a1 = a;
  endtask

  // Monitor: compares mid-cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      chk(mon_e.tag, dq_oe, dq, mon_e.oe, mon_e.dq);
    end
  end

  // Toggle oe_i mid-cycle with no clock edge (R7).
  task automatic async_oe(input logic exp_en, input logic [W-1:0] exp_word);
    @(negedge clk); #2;
    oe = 1'b0; #1;
    chk("R7 oe low mid-cycle", dq_oe, dq, 1'b0, '0);
    oe = 1'b1; #1;
    chk("R7 oe restored mid-cycle", dq_oe, dq, exp_en, exp_en ? exp_word : '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: read commands during reset never drive the bus
    ce = 1'b1; rd = 1'b1; oe = 1'b1; arr = 36'h5_5555_5555;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset quiet", dq_oe, dq, 1'b0, '0);
    pipe_mode = 1'b1;
    @(negedge clk);
    chk("R1 reset quiet pipe", dq_oe, dq, 1'b0, '0);
    ce = 1'b0; rd = 1'b0;
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 1, 36'h0_1234_5678, "R8 idle zero");

    // Flow-through: burst, deselect, read after deselect
    step(0, 1, 1, 1, 36'hA_0000_0001, "R2 ft first read");
    step(0, 1, 1, 1, 36'hA_0000_0002, "R5 ft burst");
    step(0, 1, 1, 1, 36'hA_0000_0003, "R5 ft burst");
    step(0, 0, 1, 1, 36'hA_0000_0004, "R2 ft last word");
    step(0, 1, 1, 1, 36'hA_0000_0005, "R4 ft deselect off");
    step(0, 1, 0, 1, 36'hA_0000_0006, "R6 ft read after deselect");
    step(0, 0, 0, 1, 36'hA_0000_0007, "R4 ft nonread off");
    step(0, 0, 0, 1, 36'hA_0000_0008, "R8 ft idle");

    // Pipeline: burst, deselect, read after deselect, non-read
    step(1, 1, 1, 1, 36'hB_0000_0001, "R3 pipe cmd");
    step(1, 1, 1, 1, 36'hB_0000_0002, "R3 pipe latency");
    step(1, 1, 1, 1, 36'hB_0000_0003, "R3 pipe first word");
    step(1, 0, 1, 1, 36'hB_0000_0004, "R5 pipe burst");
    step(1, 1, 1, 1, 36'hB_0000_0005, "R4 pipe previous word held");
    step(1, 1, 0, 1, 36'hB_0000_0006, "R4 pipe deselect off");
    step(1, 0, 0, 1, 36'hB_0000_0007, "R6 pipe read after deselect");
    step(1, 0, 0, 1, 36'hB_0000_0008, "R4 pipe nonread off");
    step(1, 0, 0, 1, 36'hB_0000_0009, "R8 pipe idle");

    // Output enable: synchronous view and mid-cycle toggle
    step(1, 1, 1, 1, 36'hC_0000_0001, "R7 setup");
    step(1, 1, 1, 0, 36'hC_0000_0002, "R7 oe low");
    step(1, 1, 1, 1, 36'hC_0000_0003, "R7 oe high");
    async_oe(1'b1, 36'hC_0000_0002);
    step(1, 0, 0, 1, 36'hC_0000_0004, "R5 pipe continues");
    step(0, 1, 1, 1, 36'hC_0000_0005, "R8 ft after switch");
    step(0, 0, 0, 1, 36'hC_0000_0006, "R2 ft single read");
    async_oe(1'b1, 36'hC_0000_0006);
    step(0, 0, 0, 1, 36'hC_0000_0007, "R8 final idle");
    @(negedge clk); #1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule